// File: doc/BRIEF.md
# 32-to-16-bit Access Splitting Bridge

This bridge sits between a host with a 32-bit data path and four byte-lane enables and a peripheral port that carries 16 bits per cycle. Each host request is a single beat. It carries a direction, one of four access spaces (identification, I/O, interrupt, memory), a byte address whose long-word part selects the location, the lane enables and the write data. The bridge works out the access width from the lane enables. It then runs one or two strobe/acknowledge cycles on the port and reports completion with a one-cycle done pulse, together with an error flag and the assembled read data.

Byte and 16-bit requests take exactly one port cycle. The bridge steers the selected half of the host bus onto the port lanes and returns read data on the same half. A request with all four lanes enabled becomes two back-to-back port cycles. The port address normally steps from the even to the odd 16-bit word between them. When the increment-disable input is set, both cycles use one address, and a second input chooses whether that is the odd or the even word. On a long-word read, the first cycle fills bits 15:0 and the second fills bits 31:16. The default address width gives each space an 8-Mbyte range. A watchdog counter abandons a port cycle that is never acknowledged.

Top module: `lane_split_bridge`

## Requirements
- R1: Lane-enable patterns decode as follows: exactly one bit set is a byte, 4'b0011 or 4'b1100 is a word, and 4'b1111 is a long word. Any other pattern, including 4'b0000, produces done_o and err_o together in the cycle after the request, and no port strobe.
- R2: A byte or word request runs exactly one port cycle. The port address is {addr_i[ADDR_W-1:2], h}, where h is 1 when lanes 3:2 are used and 0 otherwise. p_bsel_o equals be_i[3:2] when h is 1 and be_i[1:0] when h is 0, and p_wdata_o carries the matching host half. Address, data and selects hold steady while the strobe waits for an acknowledge.
- R3: A long-word request with increment enabled runs exactly two back-to-back port cycles, at word addresses {base,0} and then {base,1}, with p_bsel_o = 2'b11. The first cycle carries wdata_i[15:0] and the second carries wdata_i[31:16]. done_o rises only after the second acknowledge.
- R4: When inc_dis_i is set at the time of a long-word request, both port cycles use address LSB = hold_hi_i. The data halves still go out low half first.
- R5: On a long-word read, rdata_o[15:0] holds the port data from the first cycle and rdata_o[31:16] holds the port data from the second.
- R6: On a byte or word read, the port data appears on the host half chosen in R2. Bytes that are not selected, and the other half, read as zero.
- R7: p_space_o and p_we_o carry the request's space code (0 ID, 1 IO, 2 INT, 3 MEM) and direction on every port cycle of that request.
- R8: A port cycle that sees no acknowledge for TMO_CYC strobe clocks is abandoned. done_o and err_o assert, and any remaining cycle of a long word is skipped.
- R9: done_o is a single-cycle pulse. busy_o is high from acceptance until done. A request raised while busy is ignored.
- R10: After reset the bridge is idle: p_stb_o, busy_o and done_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, taken when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| space_i | input | 2 | Access space: 0 ID, 1 IO, 2 INT, 3 MEM |
| addr_i | input | ADDR_W | Host byte address; bits 1:0 are ignored |
| be_i | input | 4 | Host byte-lane enables |
| wdata_i | input | 32 | Host write data |
| inc_dis_i | input | 1 | Hold the address across the two long-word cycles |
| hold_hi_i | input | 1 | Held address uses the odd word (1) or the even word (0) |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error, valid with done_o |
| rdata_o | output | 32 | Read result, valid with done_o |
| p_stb_o | output | 1 | Port cycle strobe |
| p_we_o | output | 1 | Port cycle direction |
| p_space_o | output | 2 | Port access space |
| p_addr_o | output | ADDR_W-1 | Port 16-bit word address |
| p_bsel_o | output | 2 | Port byte selects |
| p_wdata_o | output | 16 | Port write data |
| p_ack_i | input | 1 | Port acknowledge |
| p_rdata_i | input | 16 | Port read data, valid with p_ack_i |

## Verification
The assertions check, on every cycle, the properties that hold at any instant. Address, data, selects and attributes stay stable while the strobe waits. The second long-word cycle starts straight after the first acknowledge, either at the odd word or at the held address. A rejected lane pattern starts no strobe, an expired watchdog ends the strobe with an error, and done stays one cycle wide. Other checks need whole transfers driven through the bench. These are the exact cycle count and order per request, the lane steering and zero masking of read data, the merge of two read halves, and that a request raised while busy is dropped.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  typedef enum logic [1:0] {K_BAD, K_BYTE, K_WORD, K_LONG} acc_kind_e;
  typedef enum logic {ST_IDLE, ST_CYC} bridge_state_e;
endpackage

// File: rtl/lsb_be_decode.sv
module lsb_be_decode
  import lsb_pkg::*;
(
  input  logic [3:0] be_i,
  output acc_kind_e  kind_o,
  output logic       lane_hi_o
);
  always_comb begin
    kind_o    = K_BAD;
    lane_hi_o = be_i[3] | be_i[2];
    unique case (be_i)
      4'b0001, 4'b0010, 4'b0100, 4'b1000: kind_o = K_BYTE;
      4'b0011, 4'b1100:                   kind_o = K_WORD;
      4'b1111: begin
        kind_o    = K_LONG;
        lane_hi_o = 1'b0;
      end
      default:                            kind_o = K_BAD;
    endcase
  end
endmodule

// File: rtl/lsb_cycle_timer.sv
module lsb_cycle_timer #(
  parameter int TMO_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(TMO_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == CNT_W'(TMO_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  AST_TMO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(TMO_CYC)); // R8
endmodule

// File: rtl/lsb_read_merge.sv
module lsb_read_merge (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        cap_i,
  input  logic        hi_i,
  input  logic [1:0]  mask_i,
  input  logic [15:0] pdata_i,
  output logic [31:0] rdata_o
);
  logic [15:0] masked;

  assign masked = pdata_i & {{8{mask_i[1]}}, {8{mask_i[0]}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_o <= '0;
    else if (clr_i)  rdata_o <= '0;
    else if (cap_i) begin
      if (hi_i) rdata_o[31:16] <= masked;
      else      rdata_o[15:0]  <= masked;
    end
  end
endmodule

// File: rtl/lane_split_bridge.sv
module lane_split_bridge
  import lsb_pkg::*;
#(
  parameter int ADDR_W  = 23,
  parameter int TMO_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        space_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  input  logic              inc_dis_i,
  input  logic              hold_hi_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [31:0]       rdata_o,
  output logic              p_stb_o,
  output logic              p_we_o,
  output logic [1:0]        p_space_o,
  output logic [ADDR_W-2:0] p_addr_o,
  output logic [1:0]        p_bsel_o,
  output logic [15:0]       p_wdata_o,
  input  logic              p_ack_i,
  input  logic [15:0]       p_rdata_i
);
  localparam int BASE_W = ADDR_W - 2;

  bridge_state_e     state_q;
  logic [BASE_W-1:0] base_q;
  logic [3:0]        be_q;
  logic [31:0]       wdata_q;
  logic [1:0]        space_q;
  logic              we_q, long_q, lane_hi_q, phase_q, inc_dis_q, hold_hi_q;
  logic              done_q, err_q;

  acc_kind_e kind;
  logic      lane_hi, accept, tmo_exp, data_hi, addr_lsb, last_ack;

  lsb_be_decode u_dec (
    .be_i      (be_i),
    .kind_o    (kind),
    .lane_hi_o (lane_hi)
  );

  assign accept   = (state_q == ST_IDLE) && req_i && (kind != K_BAD);
  assign p_stb_o  = (state_q == ST_CYC);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign last_ack = p_stb_o && p_ack_i && !(long_q && !phase_q);

  // long word: phase picks data half; address follows phase unless held
  assign data_hi  = long_q ? phase_q : lane_hi_q;
  assign addr_lsb = long_q ? (inc_dis_q ? hold_hi_q : phase_q) : lane_hi_q;

  assign p_addr_o  = {base_q, addr_lsb};
  assign p_wdata_o = data_hi ? wdata_q[31:16] : wdata_q[15:0];
  assign p_bsel_o  = long_q ? 2'b11 : (lane_hi_q ? be_q[3:2] : be_q[1:0]);
  assign p_we_o    = we_q;
  assign p_space_o = space_q;

  lsb_cycle_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (p_stb_o && !p_ack_i),
    .expire_o (tmo_exp)
  );

  lsb_read_merge u_merge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .cap_i   (p_stb_o && p_ack_i && !we_q),
    .hi_i    (data_hi),
    .mask_i  (p_bsel_o),
    .pdata_i (p_rdata_i),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      base_q    <= '0;
      be_q      <= '0;
      wdata_q   <= '0;
      space_q   <= '0;
      we_q      <= 1'b0;
      long_q    <= 1'b0;
      lane_hi_q <= 1'b0;
      phase_q   <= 1'b0;
      inc_dis_q <= 1'b0;
      hold_hi_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_i && kind == K_BAD) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else if (accept) begin
            state_q   <= ST_CYC;
            base_q    <= addr_i[ADDR_W-1:2];
            be_q      <= be_i;
            wdata_q   <= wdata_i;
            space_q   <= space_i;
            we_q      <= we_i;
            long_q    <= (kind == K_LONG);
            lane_hi_q <= lane_hi;
            phase_q   <= 1'b0;
            inc_dis_q <= inc_dis_i;
            hold_hi_q <= hold_hi_i;
          end
        end
        ST_CYC: begin
          if (p_ack_i) begin
            if (last_ack) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              phase_q <= 1'b1;
            end
          end else if (tmo_exp) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_BAD_NO_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i && kind == K_BAD) |=> (!p_stb_o && done_o && err_o)); // R1
  AST_HOLD_WHILE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_stb_o && !p_ack_i && !tmo_exp) |=>
      (p_stb_o && $stable(p_addr_o) && $stable(p_wdata_o) && $stable(p_bsel_o))); // R2
  AST_LONG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_stb_o && p_ack_i && long_q && !phase_q && !inc_dis_q) |=>
      (p_stb_o && p_addr_o[0] && p_bsel_o == 2'b11 && !done_o)); // R3
  AST_INCDIS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_stb_o && p_ack_i && long_q && !phase_q && inc_dis_q) |=>
      (p_stb_o && $stable(p_addr_o))); // R4
  AST_ATTR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_stb_o && !p_ack_i && !tmo_exp) |=> ($stable(p_we_o) && $stable(p_space_o))); // R7
  AST_TMO_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_exp |=> (!p_stb_o && done_o && err_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
endmodule

// File: tb/lane_split_bridge_test.sv
module lane_split_bridge_test;
  localparam int ADDR_W  = 23;
  localparam int TMO_CYC = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0, we_i = 1'b0, inc_dis_i = 1'b0, hold_hi_i = 1'b0;
  logic [1:0]        space_i = '0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [3:0]        be_i = '0;
  logic [31:0]       wdata_i = '0;
  logic              busy_o, done_o, err_o, p_stb_o, p_we_o;
  logic [31:0]       rdata_o;
  logic [1:0]        p_space_o, p_bsel_o;
  logic [ADDR_W-2:0] p_addr_o;
  logic [15:0]       p_wdata_o;
  logic              p_ack_i = 1'b0;
  logic [15:0]       p_rdata_i = '0;

  int n_tests = 0, n_fail = 0;
  int resp_dly = 0;
  bit resp_off = 1'b0;
  int rcnt = 0;
  int lg_n = 0;
  logic [ADDR_W-2:0] lg_addr [256];
  logic [15:0]       lg_wd   [256];
  logic [1:0]        lg_bs   [256];
  logic [1:0]        lg_sp   [256];
  logic              lg_we   [256];

  always #10 clk_i = ~clk_i; // 50 MHz

  lane_split_bridge #(.ADDR_W(ADDR_W), .TMO_CYC(TMO_CYC)) uut (.*);

  function automatic logic [15:0] rd_model(input logic [ADDR_W-2:0] a);
    return 16'(a * 22'd40503) ^ 16'h1234;
  endfunction

  // port responder: ack after resp_dly waiting clocks, log each completed cycle
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_ack_i <= 1'b0;
      rcnt    <= 0;
    end else if (p_ack_i || !p_stb_o || resp_off) begin
      p_ack_i <= 1'b0;
      rcnt    <= 0;
    end else if (rcnt >= resp_dly) begin
      p_ack_i   <= 1'b1;
      p_rdata_i <= rd_model(p_addr_o);
      lg_addr[lg_n[7:0]] <= p_addr_o;
      lg_wd[lg_n[7:0]]   <= p_wdata_o;
      lg_bs[lg_n[7:0]]   <= p_bsel_o;
      lg_sp[lg_n[7:0]]   <= p_space_o;
      lg_we[lg_n[7:0]]   <= p_we_o;
      lg_n <= lg_n + 1;
      rcnt <= 0;
    end else begin
      rcnt <= rcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input bit we, input logic [1:0] sp, input logic [ADDR_W-1:0] addr,
                     input logic [3:0] be, input logic [31:0] wd, input bit inc, input bit hh,
                     input int dly, input bit noack, input bit poke);
    bit is_long, is_bad, lh, got;
    int exp_n, start;
    logic [ADDR_W-2:0] ea [2];
    logic [15:0] ew [2];
    logic [1:0]  ebs;
    logic [31:0] erd, act_rd;
    logic act_err;
    is_long = (be == 4'hF);
    is_bad  = !(is_long || be == 4'h3 || be == 4'hC || $countones(be) == 1);
    lh      = !is_long && (be[3] | be[2]);
    ebs     = is_long ? 2'b11 : (lh ? be[3:2] : be[1:0]);
    exp_n   = (is_bad || noack) ? 0 : (is_long ? 2 : 1);
    erd     = '0;
    for (int i = 0; i < 2; i++) begin
      bit hi, al;
      logic [15:0] h;
      hi = is_long ? bit'(i) : lh;
      al = is_long ? (inc ? hh : bit'(i)) : lh;
      ea[i] = {addr[ADDR_W-1:2], al};
      ew[i] = hi ? wd[31:16] : wd[15:0];
      h = rd_model(ea[i]) & {{8{ebs[1]}}, {8{ebs[0]}}};
      if (i < exp_n) begin
        if (hi) erd[31:16] = h; else erd[15:0] = h;
      end
    end
    resp_dly = dly;
    resp_off = noack;
    start = lg_n;
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; space_i = sp; addr_i = addr; be_i = be;
    wdata_i = wd; inc_dis_i = inc; hold_hi_i = hh;
    @(negedge clk_i);
    req_i = 1'b0;
    got = 1'b0;
    act_err = 1'b0;
    act_rd = '0;
    for (int k = 0; k < 4 * TMO_CYC + 20 && !got; k++) begin
      if (done_o) begin
        got = 1'b1;
        act_err = err_o;
        act_rd = rdata_o;
      end else begin
        if (poke && k == 1 && busy_o) begin
          req_i = 1'b1; be_i = 4'b0001; addr_i = addr ^ 23'h40; we_i = ~we;
        end else begin
          req_i = 1'b0;
        end
        @(negedge clk_i);
      end
    end
    req_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(got, "R9 done seen", 32'(got), 32'd1);
    chk(done_o == 1'b0, "R9 done single pulse", 32'(done_o), 32'd0);
    chk(act_err == (is_bad || noack), is_bad ? "R1 err" : (noack ? "R8 timeout err" : "R2 err"),
        32'(act_err), 32'(is_bad || noack));
    chk(lg_n - start == exp_n, is_long ? "R3 cycle count" : (poke ? "R9 busy req ignored" : "R2 cycle count"),
        32'(lg_n - start), 32'(exp_n));
    if (lg_n - start == exp_n) begin
      for (int i = 0; i < exp_n; i++) begin
        int j;
        j = (start + i) % 256;
        chk(lg_addr[j] == ea[i], inc && is_long ? "R4 held address" : (is_long ? "R3 address" : "R2 address"),
            32'(lg_addr[j]), 32'(ea[i]));
        chk(lg_bs[j] == ebs, is_long ? "R3 bsel" : "R2 bsel", 32'(lg_bs[j]), 32'(ebs));
        if (we) chk(lg_wd[j] == ew[i], is_long ? "R3 wdata half" : "R2 wdata lane", 32'(lg_wd[j]), 32'(ew[i]));
        chk(lg_sp[j] == sp && lg_we[j] == we, "R7 space/dir",
            32'({lg_we[j], lg_sp[j]}), 32'({we, sp}));
      end
    end
    if (!we && !is_bad && !noack)
      chk(act_rd == erd, is_long ? "R5 merged read" : "R6 steered read", act_rd, erd);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk_i);
    chk(!p_stb_o && !busy_o && !done_o, "R10 reset idle", {29'd0, p_stb_o, busy_o, done_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!p_stb_o && !busy_o && !done_o, "R10 idle after release", {29'd0, p_stb_o, busy_o, done_o}, 32'd0);
    // directed corners
    run(1'b0, 2'd0, 23'h000100, 4'hF, 32'h0, 1'b0, 1'b0, 0, 1'b0, 1'b0); // R5 long read
    run(1'b1, 2'd3, 23'h7FFFFC, 4'hF, 32'hCAFEBABE, 1'b0, 1'b0, 2, 1'b0, 1'b0); // R3 top of range
    run(1'b0, 2'd1, 23'h001230, 4'hF, 32'h0, 1'b1, 1'b1, 1, 1'b0, 1'b0); // R4 held high
    run(1'b1, 2'd2, 23'h001230, 4'hF, 32'h11223344, 1'b1, 1'b0, 0, 1'b0, 1'b0); // R4 held low
    run(1'b0, 2'd0, 23'h000040, 4'hC, 32'h0, 1'b0, 1'b0, 0, 1'b0, 1'b0); // R6 upper word
    run(1'b0, 2'd3, 23'h000044, 4'h4, 32'h0, 1'b0, 1'b0, 1, 1'b0, 1'b0); // R6 byte lane 2
    run(1'b1, 2'd3, 23'h000048, 4'h2, 32'hA5A5_5A5A, 1'b0, 1'b0, 0, 1'b0, 1'b0); // R2 byte lane 1
    run(1'b1, 2'd1, 23'h000050, 4'h6, 32'h0, 1'b0, 1'b0, 0, 1'b0, 1'b0); // R1 misaligned word
    run(1'b0, 2'd1, 23'h000050, 4'h0, 32'h0, 1'b0, 1'b0, 0, 1'b0, 1'b0); // R1 no lanes
    run(1'b0, 2'd3, 23'h000060, 4'hF, 32'h0, 1'b0, 1'b0, 0, 1'b1, 1'b0); // R8 timeout
    run(1'b1, 2'd0, 23'h000070, 4'hF, 32'h55AA_33CC, 1'b0, 1'b0, 3, 1'b0, 1'b1); // R9 busy poke
    // constrained random
    for (int t = 0; t < 80; t++) begin
      logic [3:0] be;
      int r;
      r = int'($urandom % 8);
      case (r)
        0, 1: be = 4'hF;
        2: be = 4'h3;
        3: be = 4'hC;
        4: be = 4'(1 << ($urandom % 4));
        default: be = 4'($urandom);
      endcase
      run(1'($urandom), 2'($urandom), 23'($urandom), be, $urandom, 1'($urandom), 1'($urandom),
          int'($urandom % 4), 1'b0, 1'b0);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule